// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Controller

This block is the interrupt logic of a classic 8-bit-register UART. The receiver, transmitter and modem pins report events to it. The processor's register strobes, decoded from a 3-bit offset with separate read and write pulses, have side effects on it. It keeps one pending condition for each of four interrupt sources and masks them with the enable register. From that it drives a single registered, active-high interrupt line. It also presents the identification, line-status and modem-status register values that the bus read mux returns.

Each source clears under its own rule:
- Line errors clear on a line-status read.
- Received data clears on a receive-buffer read.
- Transmit-empty clears on a transmit-holding write, or on an identification read that reports it.
- Modem deltas clear on a modem-status read.

The identification value always names the enabled, pending source of highest priority.

The register offsets are 0 (receive-buffer read and transmit-holding write), 1 (enable), 2 (identification), 5 (line status) and 6 (modem status). Writes and reads at any other offset have no effect here.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The enable register (offset 1 write) keeps data bits 3:0. Bit 0 enables received data, bit 1 enables transmit-empty, bit 2 enables line status and bit 3 enables modem status. `ier_o` bits 7:4 read zero.
- R2: `iir_o` is 0x01 when no enabled source is pending. Otherwise bit 0 is 0, bits 2:1 hold the source code and bits 7:3 are 0. The codes are 11 for line status (0x06), 10 for received data (0x04), 01 for transmit-empty (0x02) and 00 for modem status (0x00).
- R3: When several enabled sources are pending, the one reported ranks as follows: line status first, then received data, then transmit-empty, then modem status.
- R4: `irq_o` rises one clock after any enabled source becomes pending. Clearing an enable bit drops `irq_o` one clock later but keeps the pending state, so setting the bit again reports the source again.
- R5: `lsr_o` bit 0 is data ready and bit 1 is overrun. Bits 2, 3 and 4 are the parity, framing and break flags, taken from `rx_err` bits 0, 1 and 2 on `rx_done`. Bit 5 is holding empty, bit 6 is transmitter empty and bit 7 is 0.
- R6: A line-status read (offset 5) clears bits 4:1 from the next clock. An error that arrives with `rx_done` in the same cycle is kept.
- R7: `rx_done` sets data ready and a receive-buffer read (offset 0) clears it. A character that arrives while data ready is set, with no buffer read in that cycle, sets overrun.
- R8: After reset the holding register is empty and transmit-empty is pending. A write at offset 0 clears holding empty and the pending state. `tx_taken` while the register is full sets both again.
- R9: An identification read (offset 2) clears the transmit-empty pending state only while `iir_o` reports 0x02. Reads that report other sources change nothing.
- R10: `msr_o` bits 7:4 are the inverted, two-stage synchronised levels of `modem_n` bits 3:0 (clear-to-send, data-set-ready, ring, carrier). Bits 0, 1 and 3 set on any change of their line. Bit 2 sets only when the ring input returns high.
- R11: A modem-status read (offset 6) clears `msr_o` bits 3:0 from the next clock and withdraws the modem interrupt. A delta that arrives in the same cycle is kept.
- R12: `lsr_o` bit 6 is set only when the holding register is empty and `tx_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset for the current strobe |
| reg_rd | input | 1 | One-cycle read strobe |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| rx_done | input | 1 | Receiver finished a character |
| rx_err | input | 3 | Errors of that character: parity, framing, break |
| tx_taken | input | 1 | Transmitter moved the holding byte into its shifter |
| tx_idle | input | 1 | Transmit shifter is idle |
| modem_n | input | 4 | Active-low modem inputs: clear-to-send, data-set-ready, ring, carrier |
| irq_o | output | 1 | Registered interrupt request |
| ier_o | output | 8 | Enable register value |
| iir_o | output | 8 | Identification value |
| lsr_o | output | 8 | Line-status value |
| msr_o | output | 8 | Modem-status value |

## Verification
The assertions check these rules on every cycle:
- each clear-on-access rule takes effect one clock after its strobe;
- the reported source is always the highest enabled pending bit;
- the interrupt line only rises or falls after the identification value showed the matching state.

Some behaviour only the bench scenarios can show:
- the full ranking as sources are peeled off one read at a time;
- the same-cycle races between a clear and a new event;
- the ring trailing-edge rule;
- the three-clock latency from a modem pin to its delta flag;
- that masking keeps the pending state.

A behavioural reference model in the bench is compared against every output on every clock.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int REG_AW    = 3;
    localparam int NUM_SRC   = 4;
    localparam int NUM_MODEM = 4;
    localparam int RX_ERR_W  = 3;

    localparam logic [REG_AW-1:0] OFS_DATA = 3'd0;
    localparam logic [REG_AW-1:0] OFS_IER  = 3'd1;
    localparam logic [REG_AW-1:0] OFS_IIR  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_LSR  = 3'd5;
    localparam logic [REG_AW-1:0] OFS_MSR  = 3'd6;

    // Source code equals its rank: a larger code wins.
    typedef enum logic [1:0] {
        SRC_MODEM   = 2'b00,
        SRC_TXEMPTY = 2'b01,
        SRC_RXDATA  = 2'b10,
        SRC_LINE    = 2'b11
    } src_code_e;

    typedef struct packed {
        logic rbr_rd;
        logic thr_wr;
        logic ier_wr;
        logic iir_rd;
        logic lsr_rd;
        logic msr_rd;
    } reg_strobe_t;

endpackage

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
    parameter int LINES       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RING_IDX    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINES-1:0]     modem_n,
    input  logic                 msr_rd,
    output logic [2*LINES-1:0]   msr_o,
    output logic                 pend_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][LINES-1:0] sync;
        logic [LINES-1:0]                  prev;
        logic [LINES-1:0]                  delta;
    } modem_st_t;

    modem_st_t q, d;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] evt;

    assign lvl = q.sync[SYNC_STAGES-1];

    // Per-line change detector; the ring line reacts only to its trailing edge.
    for (genvar i = 0; i < LINES; i++) begin : g_edge
        if (i == RING_IDX) begin : g_trail
            assign evt[i] = lvl[i] & ~q.prev[i];
        end else begin : g_any
            assign evt[i] = lvl[i] ^ q.prev[i];
        end
    end

    always_comb begin
        d = q;
        d.sync[0] = modem_n;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            d.sync[s] = q.sync[s-1];
        end
        d.prev  = lvl;
        d.delta = (msr_rd ? '0 : q.delta) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync  <= '1;
            q.prev  <= '1;
            q.delta <= '0;
        end else begin
            q <= d;
        end
    end

    assign msr_o  = {~lvl, q.delta};
    assign pend_o = |q.delta;

    AST_MSR_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && (evt == '0)) |=> (msr_o[LINES-1:0] == '0)); // R11

    AST_RING_NO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_rd && !q.delta[RING_IDX] && !lvl[RING_IDX]) |=> !msr_o[RING_IDX]); // R10

endmodule

// File: rtl/uart_irq_line.sv
module uart_irq_line
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_done,
    input  logic [RX_ERR_W-1:0] rx_err,
    input  logic                tx_taken,
    input  logic                tx_idle,
    input  logic                rbr_rd,
    input  logic                lsr_rd,
    input  logic                thr_wr,
    input  logic                iir_rd_thre,
    output logic [7:0]          lsr_o,
    output logic                pend_line_o,
    output logic                pend_rx_o,
    output logic                pend_tx_o
);

    localparam int ERR_W = RX_ERR_W + 1;

    typedef struct packed {
        logic             dr;
        logic [ERR_W-1:0] err;   // {break, framing, parity, overrun}
        logic             full;
        logic             thre;
    } line_st_t;

    line_st_t q, d;
    logic     ovr;

    always_comb begin
        d   = q;
        ovr = rx_done & q.dr & ~rbr_rd;

        d.dr  = rx_done | (q.dr & ~rbr_rd);
        d.err = (lsr_rd ? '0 : q.err) | (rx_done ? {rx_err, ovr} : '0);

        if (thr_wr) begin
            d.full = 1'b1;
            d.thre = 1'b0;
        end else if (tx_taken && q.full) begin
            d.full = 1'b0;
            d.thre = 1'b1;
        end else if (iir_rd_thre) begin
            d.thre = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.dr   <= 1'b0;
            q.err  <= '0;
            q.full <= 1'b0;
            q.thre <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign lsr_o       = {1'b0, ~q.full & tx_idle, ~q.full, q.err, q.dr};
    assign pend_line_o = |q.err;
    assign pend_rx_o   = q.dr;
    assign pend_tx_o   = q.thre;

    AST_LSR_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_done) |=> (lsr_o[4:1] == 4'd0)); // R6

    AST_RBR_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !rx_done) |=> !lsr_o[0]); // R7

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && lsr_o[0] && !rbr_rd) |=> lsr_o[1]); // R7

    AST_THR_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (!lsr_o[5] && !pend_tx_o)); // R8

    AST_TEMT_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_o[6] |-> (lsr_o[5] && tx_idle)); // R12

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
    parameter int NUM_SRC = 4,
    parameter int CODE_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] en_pend,
    output logic               any_o,
    output logic [CODE_W-1:0]  code_o
);

    // Higher index wins; the scan ends on the highest set bit.
    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (en_pend[i]) code_o = CODE_W'(i);
        end
    end

    assign any_o = |en_pend;

    AST_PRIO_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((en_pend >> code_o) == NUM_SRC'(1))); // R3

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_rd,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                rx_done,
    input  logic [RX_ERR_W-1:0] rx_err,
    input  logic                tx_taken,
    input  logic                tx_idle,
    input  logic [NUM_MODEM-1:0] modem_n,
    output logic                irq_o,
    output logic [7:0]          ier_o,
    output logic [7:0]          iir_o,
    output logic [7:0]          lsr_o,
    output logic [7:0]          msr_o
);

    localparam int IER_W  = NUM_SRC;
    localparam int CODE_W = $clog2(NUM_SRC);

    typedef struct packed {
        logic [IER_W-1:0] ier;
        logic             irq;
    } top_st_t;

    top_st_t      q, d;
    reg_strobe_t  stb;
    logic [NUM_SRC-1:0] en_pend;
    logic         pend_line, pend_rx, pend_tx, pend_ms;
    logic         any;
    logic [CODE_W-1:0] code;
    logic         iir_rd_thre;
    logic         unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:IER_W];

    always_comb begin
        stb.rbr_rd = reg_rd && (reg_addr == OFS_DATA);
        stb.thr_wr = reg_wr && (reg_addr == OFS_DATA);
        stb.ier_wr = reg_wr && (reg_addr == OFS_IER);
        stb.iir_rd = reg_rd && (reg_addr == OFS_IIR);
        stb.lsr_rd = reg_rd && (reg_addr == OFS_LSR);
        stb.msr_rd = reg_rd && (reg_addr == OFS_MSR);
    end

    uart_irq_line u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_done     (rx_done),
        .rx_err      (rx_err),
        .tx_taken    (tx_taken),
        .tx_idle     (tx_idle),
        .rbr_rd      (stb.rbr_rd),
        .lsr_rd      (stb.lsr_rd),
        .thr_wr      (stb.thr_wr),
        .iir_rd_thre (iir_rd_thre),
        .lsr_o       (lsr_o),
        .pend_line_o (pend_line),
        .pend_rx_o   (pend_rx),
        .pend_tx_o   (pend_tx)
    );

    uart_irq_modem #(
        .LINES       (NUM_MODEM),
        .SYNC_STAGES (SYNC_STAGES),
        .RING_IDX    (2)
    ) u_modem (
        .clk    (clk),
        .rst_n  (rst_n),
        .modem_n(modem_n),
        .msr_rd (stb.msr_rd),
        .msr_o  (msr_o),
        .pend_o (pend_ms)
    );

    // Index of each source equals its identification code.
    always_comb begin
        en_pend[SRC_LINE]    = pend_line & q.ier[2];
        en_pend[SRC_RXDATA]  = pend_rx   & q.ier[0];
        en_pend[SRC_TXEMPTY] = pend_tx   & q.ier[1];
        en_pend[SRC_MODEM]   = pend_ms   & q.ier[3];
    end

    uart_irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_pend(en_pend),
        .any_o  (any),
        .code_o (code)
    );

    assign iir_o       = any ? {5'd0, code, 1'b0} : 8'h01;
    assign iir_rd_thre = stb.iir_rd && any && (code == SRC_TXEMPTY);

    always_comb begin
        d     = q;
        d.irq = any;
        if (stb.ier_wr) d.ier = reg_wdata[IER_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq_o = q.irq;
    assign ier_o = {{(8-IER_W){1'b0}}, q.ier};

    AST_IRQ_RISE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(iir_o[0] == 1'b0)); // R4

    AST_IRQ_FALL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(iir_o == 8'h01)); // R4

    AST_IIR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_o[7:3] == 5'd0) && (iir_o[0] || (iir_o[2:1] != 2'b00) || (msr_o[3:0] != 4'd0))); // R2

    AST_OTHER_IIR_RD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.iir_rd && (iir_o == 8'h06) && !stb.thr_wr) |=> (pend_tx == $past(pend_tx) || $past(tx_taken))); // R9

endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic       rx_done = 1'b0;
    logic [2:0] rx_err = 3'd0;
    logic       tx_taken = 1'b0;
    logic       tx_idle = 1'b1;
    logic [3:0] modem_n = 4'hF;
    logic       irq_o;
    logic [7:0] ier_o, iir_o, lsr_o, msr_o;

    always #5 clk = ~clk;

    uart_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rx_done(rx_done),
        .rx_err(rx_err), .tx_taken(tx_taken), .tx_idle(tx_idle),
        .modem_n(modem_n), .irq_o(irq_o), .ier_o(ier_o), .iir_o(iir_o),
        .lsr_o(lsr_o), .msr_o(msr_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // Behavioural reference state
    bit   m_dr, m_full, m_thre, m_irq;
    logic [3:0] m_ier, m_err, m_s0, m_s1, m_prev, m_delta;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_iir();
        if (m_err != 0 && m_ier[2]) return 8'h06;
        if (m_dr && m_ier[0])       return 8'h04;
        if (m_thre && m_ier[1])     return 8'h02;
        if (m_delta != 0 && m_ier[3]) return 8'h00;
        return 8'h01;
    endfunction

    function automatic logic [7:0] m_lsr();
        return {1'b0, (!m_full && tx_idle), !m_full, m_err, m_dr};
    endfunction

    task automatic model_reset();
        m_dr = 0; m_full = 0; m_thre = 1; m_irq = 0;
        m_ier = 0; m_err = 0; m_s0 = 4'hF; m_s1 = 4'hF; m_prev = 4'hF; m_delta = 0;
    endtask

    task automatic model_clock();
        logic [7:0] cur;
        logic [3:0] ev;
        bit ovr;
        bit rbr_rd = reg_rd && reg_addr == 3'd0;
        bit thr_wr = reg_wr && reg_addr == 3'd0;
        bit ier_wr = reg_wr && reg_addr == 3'd1;
        bit iir_rd = reg_rd && reg_addr == 3'd2;
        bit lsr_rd = reg_rd && reg_addr == 3'd5;
        bit msr_rd = reg_rd && reg_addr == 3'd6;
        cur = m_iir();
        m_irq = (cur != 8'h01);
        ovr = rx_done && m_dr && !rbr_rd;
        m_dr = rx_done || (m_dr && !rbr_rd);
        m_err = (lsr_rd ? 4'd0 : m_err) | (rx_done ? {rx_err, ovr} : 4'd0);
        if (thr_wr) begin m_full = 1; m_thre = 0; end
        else if (tx_taken && m_full) begin m_full = 0; m_thre = 1; end
        else if (iir_rd && cur == 8'h02) m_thre = 0;
        ev = m_s1 ^ m_prev;
        ev[2] = m_s1[2] && !m_prev[2];
        m_delta = (msr_rd ? 4'd0 : m_delta) | ev;
        m_prev = m_s1; m_s1 = m_s0; m_s0 = modem_n;
        if (ier_wr) m_ier = reg_wdata[3:0];
    endtask

    task automatic step();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        chk("R4 irq", {7'd0, irq_o}, {7'd0, m_irq});
        chk("R1 ier", ier_o, {4'd0, m_ier});
        chk("R2 iir", iir_o, m_iir());
        chk("R5 lsr", lsr_o, m_lsr());
        chk("R10 msr", msr_o, {~m_s1, m_delta});
        reg_rd = 0; reg_wr = 0; rx_done = 0; tx_taken = 0; rx_err = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_wr = 1; step();
    endtask

    task automatic rd(input logic [2:0] a);
        reg_addr = a; reg_rd = 1; step();
    endtask

    task automatic rx(input logic [2:0] e);
        rx_done = 1; rx_err = e; step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 reset iir", iir_o, 8'h01);
        chk("R8 reset lsr", lsr_o, 8'h60);
        chk("R10 reset msr", msr_o, 8'h00);
        chk("R1 reset ier", ier_o, 8'h00);
        rst_n = 1;

        // Transmit-empty pending from reset; IIR read clears it
        wr(3'd1, 8'hF2);
        chk("R1 upper bits", ier_o, 8'h02);
        chk("R8 reset pending", iir_o, 8'h02);
        idle(1);
        chk("R4 irq rise", {7'd0, irq_o}, 8'h01);
        rd(3'd2);
        chk("R9 iir read clears", iir_o, 8'h01);
        idle(1);

        // Holding register write / taken
        wr(3'd0, 8'h0B);
        chk("R8 thr write", lsr_o, 8'h00);
        tx_taken = 1; step();
        chk("R8 empty again", lsr_o, 8'h60);
        chk("R8 re-pend", iir_o, 8'h02);
        wr(3'd0, 8'h1B);
        chk("R8 write clears pend", iir_o, 8'h01);
        tx_taken = 1; step();
        rd(3'd2);
        chk("R9 clear", iir_o, 8'h01);

        // Modem status
        wr(3'd1, 8'h08);
        modem_n[0] = 0; idle(3);
        chk("R10 cts delta", msr_o, 8'h11);
        chk("R2 modem code", iir_o, 8'h00);
        idle(1);
        rd(3'd6);
        chk("R11 msr read", msr_o, 8'h10);
        chk("R11 no pend", iir_o, 8'h01);
        modem_n[0] = 1; idle(3);
        chk("R10 cts back", msr_o, 8'h01);
        rd(3'd6);
        modem_n[2] = 0; idle(3);
        chk("R10 ring lead edge", msr_o, 8'h40);
        modem_n[2] = 1; idle(3);
        chk("R10 ring trail edge", msr_o, 8'h04);
        rd(3'd6);
        chk("R11 cleared", msr_o, 8'h00);

        // Parity error with data
        wr(3'd1, 8'h05);
        rx(3'b001);
        chk("R5 parity lsr", lsr_o, 8'h65);
        chk("R3 line first", iir_o, 8'h06);
        rd(3'd2);
        chk("R9 other read keeps", iir_o, 8'h06);
        rd(3'd0);
        chk("R7 rbr clears dr", lsr_o, 8'h64);
        rd(3'd5);
        chk("R6 lsr read clears", lsr_o, 8'h60);
        chk("R7 no rx irq", iir_o, 8'h01);
        idle(1);

        // All four pending, peeled in order
        wr(3'd1, 8'h0F);
        modem_n[0] = 0; idle(3);
        wr(3'd0, 8'h2B);
        tx_taken = 1; step();
        rx(3'b010);
        chk("R3 line", iir_o, 8'h06);
        rd(3'd5);
        chk("R3 rx data", iir_o, 8'h04);
        rd(3'd0);
        chk("R3 tx empty", iir_o, 8'h02);
        rd(3'd2);
        chk("R3 modem", iir_o, 8'h00);
        rd(3'd6);
        chk("R3 none", iir_o, 8'h01);
        modem_n[0] = 1; idle(3); rd(3'd6);

        // Masking keeps pending
        wr(3'd1, 8'h01);
        rx(3'b000);
        idle(1);
        chk("R4 irq on", {7'd0, irq_o}, 8'h01);
        wr(3'd1, 8'h00);
        chk("R4 masked iir", iir_o, 8'h01);
        idle(1);
        chk("R4 irq off", {7'd0, irq_o}, 8'h00);
        wr(3'd1, 8'h01);
        chk("R4 restored", iir_o, 8'h04);
        rd(3'd0);

        // Overrun
        rx(3'b000); rx(3'b000);
        chk("R7 overrun", lsr_o, 8'h63);
        rd(3'd5);
        chk("R6 overrun cleared", lsr_o, 8'h61);
        rd(3'd0);

        // Same-cycle error survives an LSR read
        rx(3'b100);
        chk("R5 break", lsr_o, 8'h71);
        reg_addr = 3'd5; reg_rd = 1; rx_done = 1; rx_err = 3'b010; step();
        chk("R6 new error kept", lsr_o, 8'h6B);
        rd(3'd5); rd(3'd0);
        chk("R5 clean", lsr_o, 8'h60);

        // Transmitter busy
        tx_idle = 0; step();
        chk("R12 temt needs idle", lsr_o, 8'h20);
        tx_idle = 1; step();
        chk("R12 temt", lsr_o, 8'h60);

        wr(3'd1, 8'h00);
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule